// File: doc/BRIEF.md
# Destination Address Compress Decision Unit

This block watches a byte stream that is aligned to frame boundaries. It collects the first six bytes after a start-of-frame marker into a 48-bit destination address. It then compares that address in one step against every enabled slot of a 16-slot address table. From the result it raises a single compress request. A downstream serializer uses that request to suppress the payload of frames that the local station does not need. Every frame is examined, whatever its address.

The sense of the request depends on a mode pin. In hub mode the request means "this frame is not for us": it is raised when no enabled slot holds the address. In bridge mode the request means "this frame is local": it is raised when some enabled slot holds the address.

The upstream source may stop delivering bytes in the middle of a frame, for example when its clock is inhibited during the compressed part. The decision is a register that changes only on stream beats or on the single evaluation cycle. It therefore stays put through any such pause.

The stream port is valid/ready. `in_ready` is held high at all times, so the block never applies back-pressure. A byte is consumed on every clock edge where `in_valid` is high. Cycles with `in_valid` low carry no data and advance nothing.

Top module: `dest_compress_unit`

## Requirements
- R1: While `rst_n` is low, `compress_req` is 0 and every table slot is disabled. After reset, `compress_req` stays 0 until a decision is made.
- R2: The byte accepted together with `in_sof` is bits 47:40 of the destination. The five data beats that follow fill bits 39:32, 31:24, 23:16, 15:8 and 7:0, in that order.
- R3: With `mode_sel` = 0 (hub), the decision is 1 exactly when no enabled slot equals the captured destination.
- R4: With `mode_sel` = 1 (bridge), the decision is 1 exactly when at least one enabled slot equals the captured destination.
- R5: On a clock edge with `tbl_we` high, slot `tbl_idx` takes `tbl_addr` and enable `tbl_en`. A slot written with `tbl_en` = 0 never matches, whatever address it holds.
- R6: The decision appears on `compress_req` at the clock edge after the edge that accepts the sixth address byte. `compress_req` is 0 before that edge. `mode_sel` and the table are sampled at that edge.
- R7: Once made, the decision holds across cycles with `in_valid` low (a stalled or clock-inhibited source), across further payload bytes, and across later changes of `mode_sel` or the table.
- R8: `compress_req` is 0 from the clock edge that accepts a beat carrying `in_eof`. This holds even when that beat is one of the first six.
- R9: A frame whose `in_eof` beat arrives at or before the sixth byte never raises `compress_req`.
- R10: A beat carrying `in_sof` while a frame is open restarts address capture with that byte and clears `compress_req` at that edge.
- R11: `in_ready` is always 1. Cycles with `in_valid` low change neither the capture progress nor the decision.
- R12: All 16 slots are compared at once. A match in any slot index, lowest to highest, counts equally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Stream byte present this cycle |
| in_ready | output | 1 | Always 1; the block never stalls the stream |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| mode_sel | input | 1 | 0 = hub (request on miss), 1 = bridge (request on hit) |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 4 | Table slot to write |
| tbl_addr | input | 48 | Address written into the slot |
| tbl_en | input | 1 | Enable written into the slot |
| compress_req | output | 1 | Compress request for the current frame |

## Verification
A beat on edge k affects the result as follows. An `in_eof` or `in_sof` beat clears the request at edge k itself. A beat that completes the sixth address byte produces the decision at edge k+1. A table write on edge k is first seen by an evaluation at edge k+1 or later. The bench drives inputs on the falling edge. Its behavioural model applies the same timings at each rising edge, using the input values present before that edge. The request is compared against the model at every falling edge, so an early, late or dropped decision shows up in the exact cycle where it goes wrong. Stalls of many cycles and mode changes are placed directly after a decision, to catch a request that drifts while the source is quiet.

// File: rtl/dcu_pkg.sv
package dcu_pkg;
  localparam int unsigned DCU_BYTE_W  = 8;
  localparam int unsigned DCU_ADDR_BY = 6;
  localparam int unsigned DCU_SLOTS   = 16;

  typedef enum logic {
    POL_HUB    = 1'b0,
    POL_BRIDGE = 1'b1
  } dcu_pol_e;
endpackage

// File: rtl/dcu_capture.sv
module dcu_capture #(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned ADDR_BY = 6,
  localparam int unsigned AW = BYTE_W * ADDR_BY,
  localparam int unsigned CW = $clog2(ADDR_BY + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              sof,
  input  logic              eof,
  input  logic [BYTE_W-1:0] data,
  output logic [AW-1:0]     dst,
  output logic              dst_done
);
  logic [CW-1:0] seen_q;
  logic          open_q;
  logic          last_byte;

  assign last_byte = (seen_q == CW'(ADDR_BY - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q   <= '0;
      open_q   <= 1'b0;
      dst      <= '0;
      dst_done <= 1'b0;
    end else begin
      dst_done <= 1'b0;
      if (beat) begin
        if (eof) begin
          open_q <= 1'b0;
          seen_q <= '0;
        end else if (sof) begin
          open_q   <= 1'b1;
          seen_q   <= CW'(1);
          dst      <= {dst[AW-BYTE_W-1:0], data};
          dst_done <= (ADDR_BY == 1);
        end else if (open_q && (seen_q < CW'(ADDR_BY))) begin
          seen_q   <= seen_q + CW'(1);
          dst      <= {dst[AW-BYTE_W-1:0], data};
          dst_done <= last_byte;
        end
      end
    end
  end
endmodule

// File: rtl/dcu_table.sv
module dcu_table #(
  parameter int unsigned AW    = 48,
  parameter int unsigned SLOTS = 16,
  localparam int unsigned IW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_en,
  input  logic [AW-1:0] probe,
  output logic          any_hit
);
  logic [AW-1:0]    slot_q [SLOTS];
  logic [SLOTS-1:0] live_q;
  logic [SLOTS-1:0] hit_vec;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[s] <= '0;
        live_q[s] <= 1'b0;
      end else if (we && (idx == IW'(s))) begin
        slot_q[s] <= wr_addr;
        live_q[s] <= wr_en;
      end
    end
    assign hit_vec[s] = live_q[s] && (slot_q[s] == probe);
  end

  assign any_hit = |hit_vec;
endmodule

// File: rtl/dcu_decide.sv
module dcu_decide
  import dcu_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     beat,
  input  logic     sof,
  input  logic     eof,
  input  logic     evaluate,
  input  logic     any_hit,
  input  dcu_pol_e pol,
  output logic     req
);
  logic verdict;

  always_comb begin
    unique case (pol)
      POL_BRIDGE: verdict = any_hit;
      default:    verdict = !any_hit;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    req <= 1'b0;
    else if (beat && (eof || sof)) req <= 1'b0;
    else if (evaluate)             req <= verdict;
  end
endmodule

// File: rtl/dest_compress_unit.sv
module dest_compress_unit
  import dcu_pkg::*;
#(
  parameter int unsigned BYTE_W  = DCU_BYTE_W,
  parameter int unsigned ADDR_BY = DCU_ADDR_BY,
  parameter int unsigned SLOTS   = DCU_SLOTS,
  localparam int unsigned AW = BYTE_W * ADDR_BY,
  localparam int unsigned IW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              mode_sel,
  input  logic              tbl_we,
  input  logic [IW-1:0]     tbl_idx,
  input  logic [AW-1:0]     tbl_addr,
  input  logic              tbl_en,
  output logic              compress_req
);
  logic [AW-1:0] dst;
  logic          dst_done;
  logic          any_hit;
  dcu_pol_e      pol;

  assign in_ready = 1'b1;
  assign pol      = dcu_pol_e'(mode_sel);

  dcu_capture #(.BYTE_W(BYTE_W), .ADDR_BY(ADDR_BY)) u_cap (
    .clk(clk), .rst_n(rst_n), .beat(in_valid), .sof(in_sof), .eof(in_eof),
    .data(in_data), .dst(dst), .dst_done(dst_done)
  );

  dcu_table #(.AW(AW), .SLOTS(SLOTS)) u_tbl (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .idx(tbl_idx), .wr_addr(tbl_addr),
    .wr_en(tbl_en), .probe(dst), .any_hit(any_hit)
  );

  dcu_decide u_dec (
    .clk(clk), .rst_n(rst_n), .beat(in_valid), .sof(in_sof), .eof(in_eof),
    .evaluate(dst_done), .any_hit(any_hit), .pol(pol), .req(compress_req)
  );
endmodule

// File: rtl/dcu_checker.sv
module dcu_checker #(
  parameter int unsigned ADDR_BY = 6
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_sof,
  input logic in_eof,
  input logic compress_req
);
  logic [3:0] nbytes;
  logic       sixth_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nbytes  <= '0;
      sixth_q <= 1'b0;
    end else begin
      sixth_q <= 1'b0;
      if (in_valid) begin
        if (in_eof) nbytes <= '0;
        else if (in_sof) begin
          nbytes  <= 4'd1;
          sixth_q <= (ADDR_BY == 1);
        end else if (nbytes != 0 && 32'(nbytes) < ADDR_BY) begin
          nbytes  <= nbytes + 4'd1;
          sixth_q <= (32'(nbytes) == ADDR_BY - 1);
        end
      end
    end
  end

  // R1
  always @(posedge clk) begin
    if (!rst_n) reset_quiet_chk: assert (!compress_req);
  end

  // R8
  eof_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eof) |=> !compress_req);

  // R10
  sof_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> !compress_req);

  // R6
  rise_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(compress_req) |-> $past(sixth_q));

  // R7
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (compress_req && !in_valid) |=> compress_req);
endmodule

bind dest_compress_unit dcu_checker #(.ADDR_BY(ADDR_BY)) u_dcu_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
  .in_eof(in_eof), .compress_req(compress_req)
);

// File: tb/tb_dest_compress_unit.sv
module tb_dest_compress_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_sof = 1'b0;
  logic        in_eof = 1'b0;
  logic        mode_sel = 1'b0;
  logic        tbl_we = 1'b0;
  logic [3:0]  tbl_idx = '0;
  logic [47:0] tbl_addr = '0;
  logic        tbl_en = 1'b0;
  logic        compress_req;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  dest_compress_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .mode_sel(mode_sel),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_addr(tbl_addr), .tbl_en(tbl_en),
    .compress_req(compress_req)
  );

  // behavioural reference
  logic [47:0] m_tbl [16];
  bit          m_en  [16];
  logic [7:0]  m_q [$];
  bit          m_open, m_pend, m_exp, m_hit;
  logic [47:0] m_dst;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < 16; e++) begin m_tbl[e] = '0; m_en[e] = 0; end
      m_q.delete(); m_open = 0; m_pend = 0; m_exp = 0;
    end else begin
      if (m_pend) begin
        m_dst = {m_q[0], m_q[1], m_q[2], m_q[3], m_q[4], m_q[5]};
        m_hit = 0;
        for (int e = 0; e < 16; e++) if (m_en[e] && m_tbl[e] == m_dst) m_hit = 1;
        m_exp  = mode_sel ? m_hit : !m_hit;
        m_pend = 0;
      end
      if (in_valid) begin
        if (in_eof) begin
          m_q.delete(); m_open = 0; m_pend = 0; m_exp = 0;
        end else if (in_sof) begin
          m_q.delete(); m_q.push_back(in_data); m_open = 1; m_pend = 0; m_exp = 0;
        end else if (m_open && m_q.size() < 6) begin
          m_q.push_back(in_data);
          if (m_q.size() == 6) m_pend = 1;
        end
      end
      if (tbl_we) begin m_tbl[tbl_idx] = tbl_addr; m_en[tbl_idx] = tbl_en; end
    end
  end

  always @(negedge clk) begin
    cycles++;
    checks++;
    if (compress_req !== m_exp) begin
      fails++;
      $display("FAIL %s cycle %0d: compress_req=%0b expected %0b", cur_req, cycles, compress_req, m_exp);
    end
    checks++;
    if (in_ready !== 1'b1) begin // R11
      fails++;
      $display("FAIL R11 cycle %0d: in_ready=%0b expected 1", cycles, in_ready);
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic beat(input logic [7:0] d, input bit s, input bit e);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'hxx;
    end
  endtask

  task automatic wr(input int i, input logic [47:0] a, input bit en);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 4'(i); tbl_addr = a; tbl_en = en;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic frame(input logic [47:0] a, input int payload, input int gap);
    for (int i = 0; i < 6; i++) begin
      beat(a[47-8*i -: 8], i == 0, 1'b0);
      if (gap > 0) idle(gap);
    end
    for (int i = 0; i < payload; i++) beat(8'(i + 8'h40), 1'b0, 1'b0);
    beat(8'hEE, 1'b0, 1'b1);
    idle(2);
  endtask

  localparam logic [47:0] A = 48'h02_11_22_33_44_55;
  localparam logic [47:0] B = 48'h0A_BB_CC_DD_EE_F0;
  localparam logic [47:0] C = 48'h06_01_02_03_04_05;
  localparam logic [47:0] D = 48'hFF_FF_FF_FF_FF_FF;

  initial begin
    cur_req = "R1";
    idle(4);
    rst_n = 1'b1;
    idle(3);

    cur_req = "R5";
    wr(0, A, 1'b1);
    wr(15, B, 1'b1);
    wr(7, C, 1'b0);

    cur_req = "R3"; mode_sel = 1'b0;
    frame(D, 4, 0);
    frame(A, 4, 0);
    frame(C, 2, 0);

    cur_req = "R4"; mode_sel = 1'b1;
    frame(B, 3, 0);
    frame(D, 3, 0);

    cur_req = "R5";
    frame(C, 3, 0);

    cur_req = "R2";
    frame(48'h55_44_33_22_11_02, 2, 0);
    frame(A, 2, 0);

    cur_req = "R6";
    frame(A, 3, 3);
    mode_sel = 1'b0;
    frame(D, 1, 1);

    cur_req = "R7"; mode_sel = 1'b1;
    for (int i = 0; i < 6; i++) beat(A[47-8*i -: 8], i == 0, 1'b0);
    idle(12);
    mode_sel = 1'b0;
    wr(0, A, 1'b0);
    idle(5);
    beat(8'h01, 1'b0, 1'b0);
    idle(4);
    beat(8'h02, 1'b0, 1'b0);

    cur_req = "R8";
    beat(8'hEE, 1'b0, 1'b1);
    idle(3);
    wr(0, A, 1'b1);

    cur_req = "R9"; mode_sel = 1'b0;
    beat(D[47:40], 1'b1, 1'b0);
    beat(D[39:32], 1'b0, 1'b0);
    beat(D[31:24], 1'b0, 1'b0);
    beat(D[23:16], 1'b0, 1'b1);
    idle(4);
    for (int i = 0; i < 5; i++) beat(D[47-8*i -: 8], i == 0, 1'b0);
    beat(D[7:0], 1'b0, 1'b1);
    idle(4);

    cur_req = "R10"; mode_sel = 1'b1;
    for (int i = 0; i < 3; i++) beat(D[47-8*i -: 8], i == 0, 1'b0);
    frame(B, 2, 0);
    for (int i = 0; i < 6; i++) beat(B[47-8*i -: 8], i == 0, 1'b0);
    beat(8'h11, 1'b0, 1'b0);
    frame(D, 1, 0);

    cur_req = "R11";
    frame(B, 0, 2);

    cur_req = "R12"; mode_sel = 1'b1;
    for (int s = 0; s < 16; s++) wr(s, 48'h0C_00_00_00_10_00 + 48'(s), 1'b1);
    for (int s = 0; s < 16; s++) frame(48'h0C_00_00_00_10_00 + 48'(s), 1, 0);
    mode_sel = 1'b0;
    frame(48'h0C_00_00_00_10_00 + 48'd16, 1, 0);
    frame(48'h0C_00_00_00_10_0F, 1, 0);

    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule